// File: doc/BRIEF.md
# Packed Butterfly Multiply-Round-Shift Unit

This unit performs a scaled butterfly on packed signed data, the core step of FFT and DCT kernels. Three 64-bit operand words, T, A and B, each hold several two's-complement lanes of a selectable width. For every lane the unit forms T+A and T−A and multiplies both by the B lane. It rounds each product half-up and shifts it arithmetically right by an immediate amount. The sum results and the difference results come out as two packed words.

The unit is a two-stage pipeline that accepts one operation per cycle. A caller drives the three words, a width code and a shift amount together with a valid strobe. Two cycles later it receives both result words and a valid flag. A shift that is too large for the chosen width is clamped, and the result is marked with an error flag.

Top module: `packed_butterfly_rs`

## Requirements
- R1: The width code selects the lane width: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. A word holds 64/width lanes. Lane i is bits [i*width +: width], read as a signed value, and every lane is computed independently.
- R2: Each lane of the sum word equals the rounded, shifted value of (T+A)*B, computed without intermediate overflow.
- R3: Each lane of the difference word equals the rounded, shifted value of (T−A)*B, computed without intermediate overflow.
- R4: Rounding is half-up: the lane result is floor(product / 2^shift + 1/2). Exact halves therefore round toward positive infinity.
- R5: With a shift of 0 the lane result is the product itself, truncated to the lane width.
- R6: Each lane result keeps only its low `width` bits, wrapping modulo 2^width. This includes lanes that hold the most negative value.
- R7: The largest usable shift is min(32, width) − 1, which is 7, 15, 31 and 31 for the four widths. A larger shift request is replaced by that limit.
- R8: The error flag is high together with exactly those results whose requested shift was above the limit. It is low at all other times.
- R9: A result appears with the valid flag exactly two cycles after its inputs were accepted with the valid strobe. Both words update together, and the valid flag appears at no other time.
- R10: During reset the valid flag, the error flag and both result words are zero.
- R11: While no new result is presented, both result words hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| inT | input | 64 | Packed T operand |
| inA | input | 64 | Packed A operand |
| inB | input | 64 | Packed B multiplier |
| inWidth | input | 2 | Lane width code (R1) |
| inShift | input | 6 | Requested right-shift amount |
| outValid | output | 1 | Result valid |
| outSum | output | 64 | Packed scaled sums |
| outDiff | output | 64 | Packed scaled differences |
| outShiftErr | output | 1 | Shift was clamped for this result |

## Verification
Seeded random operands are applied at every width, each with shifts of zero, a middle value and the limit. This separates lane-slicing faults from rounding faults and from shift faults. Directed words place the most negative value in every lane and pick values whose scaled product lands on an exact half of either sign, which exposes wrong wrap-around and round-toward-zero behaviour. Shift requests just above the limit, and far above it, show whether clamping and the error flag follow the lane width. Back-to-back issue followed by idle cycles checks that results arrive two cycles after issue and then hold.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  localparam int WORD_W    = 64;
  localparam int SHIFT_W   = 6;
  localparam int SHIFT_CAP = 32;
  localparam int NUM_EW    = 4;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ewSel_e;

  typedef struct packed {
    logic ldStage1;
    logic ldStage2;
  } bflyStrobe_t;

  function automatic int laneBits(ewSel_e sel);
    return 8 << int'(sel);
  endfunction

  function automatic logic [SHIFT_W-1:0] maxShift(ewSel_e sel);
    int ew;
    ew = laneBits(sel);
    return SHIFT_W'(((ew < SHIFT_CAP) ? ew : SHIFT_CAP) - 1);
  endfunction

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
#(
  parameter int SHW = SHIFT_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  ewSel_e         inWidth,
  input  logic [SHW-1:0] inShift,
  output bflyStrobe_t    strobe,
  output logic [SHW-1:0] shiftEff,
  output logic           outValid,
  output logic           outShiftErr
);

  logic [SHW-1:0] shiftCap;
  logic           overLimit;
  logic           s1Valid;
  logic           s1Err;

  always_comb begin
    shiftCap  = SHW'(maxShift(inWidth));
    overLimit = inShift > shiftCap;
    shiftEff  = overLimit ? shiftCap : inShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid     <= 1'b0;
      s1Err       <= 1'b0;
      outValid    <= 1'b0;
      outShiftErr <= 1'b0;
    end else begin
      s1Valid     <= inValid;
      s1Err       <= inValid & overLimit;
      outValid    <= s1Valid;
      outShiftErr <= s1Valid & s1Err;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.ldStage1 = inValid;
    strobe.ldStage2 = s1Valid;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid); // R9
  AST_ERR_WITH_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    outShiftErr |-> outValid); // R8
  AST_ERR_TRACKS_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inShift > shiftCap) |-> ##2 outShiftErr); // R8

endmodule

// File: rtl/bfly_datapath.sv
module bfly_datapath
  import bfly_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int SHW    = SHIFT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bflyStrobe_t       strobe,
  input  logic [DATA_W-1:0] inT,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  ewSel_e            inWidth,
  input  logic [SHW-1:0]    shiftEff,
  output logic [DATA_W-1:0] outSum,
  output logic [DATA_W-1:0] outDiff
);

  logic [DATA_W-1:0] s1T, s1A, s1B;
  ewSel_e            s1Width;
  logic [SHW-1:0]    s1Shift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1T     <= '0;
      s1A     <= '0;
      s1B     <= '0;
      s1Width <= EW8;
      s1Shift <= '0;
    end else if (strobe.ldStage1) begin
      s1T     <= inT;
      s1A     <= inA;
      s1B     <= inB;
      s1Width <= inWidth;
      s1Shift <= shiftEff;
    end
  end

  logic [DATA_W-1:0] varSum  [NUM_EW];
  logic [DATA_W-1:0] varDiff [NUM_EW];

  for (genvar k = 0; k < NUM_EW; k++) begin : g_width
    localparam int EW    = 8 << k;
    localparam int LANES = DATA_W / EW;
    localparam int PW    = 2 * EW + 2;

    logic [DATA_W-1:0] vSum, vDiff;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic signed [EW-1:0] tL, aL, bL;
      logic signed [PW-1:0] sumX, difX, bX, pS, pD, rnd, rS, rD;

      always_comb begin
        tL   = s1T[l*EW +: EW];
        aL   = s1A[l*EW +: EW];
        bL   = s1B[l*EW +: EW];
        sumX = PW'(tL) + PW'(aL);
        difX = PW'(tL) - PW'(aL);
        bX   = PW'(bL);
        pS   = sumX * bX;
        pD   = difX * bX;
        rnd  = (PW'(1) << s1Shift) >> 1;
        rS   = (pS + rnd) >>> s1Shift;
        rD   = (pD + rnd) >>> s1Shift;
      end

      assign vSum[l*EW +: EW]  = EW'(rS);
      assign vDiff[l*EW +: EW] = EW'(rD);
    end

    assign varSum[k]  = vSum;
    assign varDiff[k] = vDiff;
  end

  logic [DATA_W-1:0] nextSum, nextDiff;

  always_comb begin
    nextSum  = varSum[int'(s1Width)];
    nextDiff = varDiff[int'(s1Width)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outSum  <= '0;
      outDiff <= '0;
    end else if (strobe.ldStage2) begin
      outSum  <= nextSum;
      outDiff <= nextDiff;
    end
  end

  AST_SHIFT_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    s1Shift <= SHW'(maxShift(s1Width))); // R7
  AST_ZERO_MULTIPLIER: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldStage2 && s1B == '0) |=> (outSum == '0 && outDiff == '0)); // R2
  AST_EQUAL_OPERANDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldStage2 && s1A == '0) |=> (outSum == outDiff)); // R3
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldStage2 |=> ($stable(outSum) && $stable(outDiff))); // R11

endmodule

// File: rtl/packed_butterfly_rs.sv
module packed_butterfly_rs
  import bfly_pkg::*;
#(
  parameter int DATA_W = WORD_W,
  parameter int SHW    = SHIFT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inT,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [1:0]        inWidth,
  input  logic [SHW-1:0]    inShift,
  output logic              outValid,
  output logic [DATA_W-1:0] outSum,
  output logic [DATA_W-1:0] outDiff,
  output logic              outShiftErr
);

  ewSel_e         widthSel;
  bflyStrobe_t    strobe;
  logic [SHW-1:0] shiftEff;

  assign widthSel = ewSel_e'(inWidth);

  bfly_ctrl #(.SHW(SHW)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inWidth    (widthSel),
    .inShift    (inShift),
    .strobe     (strobe),
    .shiftEff   (shiftEff),
    .outValid   (outValid),
    .outShiftErr(outShiftErr)
  );

  bfly_datapath #(.DATA_W(DATA_W), .SHW(SHW)) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inT     (inT),
    .inA     (inA),
    .inB     (inB),
    .inWidth (widthSel),
    .shiftEff(shiftEff),
    .outSum  (outSum),
    .outDiff (outDiff)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!outValid && !outShiftErr && outSum == '0 && outDiff == '0)); // R10

endmodule

// File: tb/test_packed_butterfly_rs.sv
`timescale 1ns/1ps
module test_packed_butterfly_rs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] inT = '0, inA = '0, inB = '0;
  logic [1:0]  inWidth = '0;
  logic [5:0]  inShift = '0;
  logic        outValid, outShiftErr;
  logic [63:0] outSum, outDiff;

  always #10 clk = ~clk;

  packed_butterfly_rs i_packed_butterfly_rs (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inT(inT), .inA(inA), .inB(inB),
    .inWidth(inWidth), .inShift(inShift),
    .outValid(outValid), .outSum(outSum), .outDiff(outDiff),
    .outShiftErr(outShiftErr)
  );

  typedef struct {
    logic [63:0] s;
    logic [63:0] d;
    bit          e;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails = 0;
  int          cycle = 0;
  bit          done = 0;
  logic [63:0] lastSum = '0, lastDiff = '0;

  always @(posedge clk) cycle++;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void refCalc(input logic [63:0] t, a, b,
                                  input logic [1:0] ws, input logic [5:0] sh,
                                  output logic [63:0] rs, rd, output bit e);
    int ew, mx, s;
    ew = 8 << ws;
    mx = ((ew < 32) ? ew : 32) - 1;
    s  = int'(sh);
    e  = (s > mx);
    if (e) s = mx;
    rs = '0;
    rd = '0;
    for (int i = 0; i < 64 / ew; i++) begin
      logic signed [139:0] tv, av, bv, ps, pd, qs, qd;
      for (int j = 0; j < 140; j++) begin
        int src;
        src = i * ew + ((j < ew) ? j : ew - 1);
        tv[j] = t[src];
        av[j] = a[src];
        bv[j] = b[src];
      end
      ps = (tv + av) * bv;
      pd = (tv - av) * bv;
      qs = ((ps <<< 1) + (140'sd1 <<< s)) >>> (s + 1);
      qd = ((pd <<< 1) + (140'sd1 <<< s)) >>> (s + 1);
      for (int j = 0; j < ew; j++) begin
        rs[i * ew + j] = qs[j];
        rd[i * ew + j] = qd[j];
      end
    end
  endfunction

  task automatic issue(input logic [63:0] t, a, b, input logic [1:0] ws,
                       input logic [5:0] sh, input string tag);
    exp_t it;
    @(negedge clk);
    inT = t; inA = a; inB = b; inWidth = ws; inShift = sh; inValid = 1'b1;
    refCalc(t, a, b, ws, sh, it.s, it.d, it.e);
    it.cyc = cycle;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected valid", 64'(outValid), 64'd0);
      end else begin
        exp_t it;
        it = sb.pop_front();
        check(outSum == it.s, {it.tag, " R2 sum"}, outSum, it.s);
        check(outDiff == it.d, {it.tag, " R3 diff"}, outDiff, it.d);
        check(outShiftErr == it.e, {it.tag, " R8 err"}, 64'(outShiftErr), 64'(it.e));
        check(cycle - it.cyc == 2, {it.tag, " R9 latency"},
              64'(cycle - it.cyc), 64'd2);
        lastSum  = outSum;
        lastDiff = outDiff;
      end
    end else if (rstN) begin
      check(outShiftErr == 1'b0, "R8 err without result", 64'(outShiftErr), 64'd0);
    end
  end

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R10 reset valid", 64'(outValid), 64'd0);
    check(outSum == '0, "R10 reset sum", outSum, 64'd0);
    check(outDiff == '0, "R10 reset diff", outDiff, 64'd0);
    check(outShiftErr == 1'b0, "R10 reset err", 64'(outShiftErr), 64'd0);
    rstN = 1'b1;
    idle(2);

    // R4: exact halves of both signs, width 8, shift 1
    issue(64'h0101_0101_0101_0101, 64'h0, 64'h0101_0101_0101_0101, 2'd0, 6'd1, "R4 pos half");
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0101_0101_0101_0101, 2'd0, 6'd1, "R4 neg half");
    issue(64'h0003_FFFD_0005_FFFB, 64'h0000_0000_0002_0002, 64'h0001_0001_0001_0001, 2'd1, 6'd2, "R4 mixed");
    // R5: shift zero
    issue(64'h1234_8765_7FFF_0001, 64'h0F0F_F0F0_0001_8000, 64'h0003_FFFE_0002_7FFF, 2'd1, 6'd0, "R5");
    // R1: distinct lanes per width
    issue(64'h0102_0304_0506_0708, 64'h1010_2020_3030_4040, 64'h0203_0405_0607_0809, 2'd0, 6'd3, "R1 w8");
    issue(64'h0001_0002_0003_0004, 64'h0100_0200_0300_0400, 64'h0005_0006_0007_0008, 2'd2, 6'd4, "R1 w32");
    // R6: most negative lanes at each width
    issue(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 2'd0, 6'd0, "R6 w8");
    issue(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'd1, 6'd15, "R6 w16");
    issue(64'h8000_0000_8000_0000, 64'h7FFF_FFFF_8000_0000, 64'h8000_0000_7FFF_FFFF, 2'd2, 6'd31, "R6 w32");
    issue(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 2'd3, 6'd31, "R6 w64");
    // R7/R8: shift limits
    issue(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 64'h7F7F_7F7F_7F7F_7F7F, 2'd0, 6'd7, "R7 w8 at limit");
    issue(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 64'h7F7F_7F7F_7F7F_7F7F, 2'd0, 6'd8, "R7 R8 w8 over");
    issue(rnd64(), rnd64(), rnd64(), 2'd0, 6'd40, "R7 R8 w8 far");
    issue(rnd64(), rnd64(), rnd64(), 2'd1, 6'd16, "R7 R8 w16 over");
    issue(rnd64(), rnd64(), rnd64(), 2'd3, 6'd32, "R7 R8 w64 over");
    issue(rnd64(), rnd64(), rnd64(), 2'd2, 6'd63, "R7 R8 w32 far");
    idle(4);

    // Seeded random sweep: all widths, shifts zero, middle and limit
    for (int ws = 0; ws < 4; ws++) begin
      int ew, mx;
      ew = 8 << ws;
      mx = ((ew < 32) ? ew : 32) - 1;
      for (int k = 0; k < 3; k++) begin
        int sh;
        sh = (k == 0) ? 0 : ((k == 1) ? mx / 2 : mx);
        for (int n = 0; n < 20; n++) begin
          issue(rnd64(), rnd64(), rnd64(), 2'(ws), 6'(sh), "R1 R4 R6 random");
        end
        idle(1 + k);
      end
    end

    idle(4);
    check(sb.size() == 0, "R9 scoreboard drained", 64'(sb.size()), 64'd0);
    // R11: outputs hold while idle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(outSum == lastSum, "R11 hold sum", outSum, lastSum);
      check(outDiff == lastDiff, "R11 hold diff", outDiff, lastDiff);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule